// File: doc/BRIEF.md
# Two-Step Adaptive Baseline Corrector

This block removes a slowly drifting baseline from a stream of signed samples. Each sample is the integrated charge of one RF bucket, about 18.8 ns of beam. Stage one finds the lowest sample in every window of a programmable number of valid samples. Each window minimum goes into a 64-entry running average, which gives a floor estimate. Subtracting the floor from the incoming sample gives a floor-restored value.

Stage two treats floor-restored values below a programmable threshold as baseline. Values at or above the threshold are peaks. Only the baseline values enter a second 64-entry running average, which is the final baseline. The corrected output is the floor-restored value minus that final baseline. Both subtractions clamp to the signed output range.

The output is registered and appears one clock after its input sample. Both subtractions use the average values in effect before that same sample updates them. Two ready flags tell the consumer when each average has been filled with 64 real entries.

Top module: `blc_top`

## Requirements
- R1: `out_valid` is high exactly one clock after each clock in which `in_valid` is high. In a clock without `in_valid`, `out_valid` drops and `out_sample` keeps its last value.
- R2: Stage one splits the valid samples into consecutive windows of L samples. L is `cfg_win_len`, with 0 treated as 1. On the last sample of each window, the minimum of that window (this sample included) is pushed into the floor average.
- R3: The floor value is the sum of the last 64 pushed minima, divided by 64 with an arithmetic right shift of 6 (rounding toward minus infinity). Slots not yet written count as zero.
- R4: For a valid sample x, the floor-restored value is r = sat(x - floor). The floor used is the value held before this sample's own push.
- R5: r is accepted as baseline only when r < `cfg_threshold`, compared as signed 16-bit values with a strict inequality. Each accepted r is pushed into the final-baseline average, which follows the same 64-entry, shift-by-6 rule as R3.
- R6: A sample with r at or above the threshold leaves the final baseline unchanged.
- R7: `out_sample` = sat(r - base), where base is the final baseline held before this sample's own push.
- R8: Both subtractions saturate to the range -32768 to 32767 instead of wrapping.
- R9: `floor_ready` rises once 64 minima have been pushed. `base_ready` rises once 64 samples have been accepted. Both flags stay high until reset.
- R10: After reset, `out_valid`, `out_sample`, `floor_ready` and `base_ready` are all zero, and both averages start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed bucket intensity |
| cfg_win_len | input | 8 | Minimum-search window length in samples (0 means 1) |
| cfg_threshold | input | 16 | Signed acceptance threshold on floor-restored values |
| out_valid | output | 1 | Corrected sample strobe |
| out_sample | output | 16 | Signed corrected sample |
| floor_ready | output | 1 | Floor average holds 64 real minima |
| base_ready | output | 1 | Final-baseline average holds 64 accepted samples |

## Verification
The first pattern uses a window longer than the run, so the floor stays at zero. That isolates stage two. It mixes values below, exactly at and above the threshold, and full-scale extremes, which separates the strict comparison, the hold on rejected peaks, the floor-rounding shift and positive saturation. The second pattern is a falling ramp with periodic large peaks and a window of four. Against a reference model it shows whether window boundaries, the minimum selection and the floor ready point at the 64th push are right. The third pattern uses a window length of zero, with large positive samples followed by full-scale negatives. It separates the zero-as-one rule and drives negative saturation through the floor path.

// File: rtl/blc_pkg.sv
`timescale 1ns/1ps
package blc_pkg;
  // log2 of the running-average depth (64 entries)
  localparam int unsigned BLC_AVG_LOG2 = 6;
  localparam int unsigned BLC_DW       = 16;
  localparam int unsigned BLC_WIN_W    = 8;
endpackage

// File: rtl/blc_sat_sub.sv
`timescale 1ns/1ps
module blc_sat_sub #(
  parameter int unsigned DW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW-1:0] y
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0] diff;

  always_comb begin
    diff = {a[DW-1], a} - {b[DW-1], b};
    if (diff[DW] != diff[DW-1]) begin
      y = diff[DW] ? MINV : MAXV;
    end else begin
      y = diff[DW-1:0];
    end
  end
endmodule

// File: rtl/blc_win_min.sv
`timescale 1ns/1ps
module blc_win_min #(
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic signed [DW-1:0] din,
  input  logic [LW-1:0]        win_len,
  output logic                 push,
  output logic signed [DW-1:0] min_out
);
  logic [LW-1:0]        cnt_q, cnt_d;
  logic signed [DW-1:0] min_q, min_d;
  logic [LW-1:0]        len_eff;
  logic                 last;
  logic signed [DW-1:0] cand;

  always_comb begin
    len_eff = (win_len == '0) ? {{(LW-1){1'b0}}, 1'b1} : win_len;
    last    = (cnt_q >= len_eff - 1'b1);
    if (cnt_q == '0) begin
      cand = din;
    end else begin
      cand = (din < min_q) ? din : min_q;
    end
    push    = valid && last;
    min_out = cand;
    min_d   = min_q;
    cnt_d   = cnt_q;
    if (valid) begin
      min_d = cand;
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      min_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      min_q <= min_d;
    end
  end
endmodule

// File: rtl/blc_avg_ring.sv
`timescale 1ns/1ps
module blc_avg_ring #(
  parameter int unsigned DW   = 16,
  parameter int unsigned LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] avg,
  output logic                 ready
);
  localparam int unsigned DEPTH = 1 << LOG2;
  localparam int unsigned SW    = DW + LOG2;

  logic signed [DW-1:0] store [DEPTH];
  logic signed [SW-1:0] sum_q, sum_d, shr;
  logic [LOG2-1:0]      wp_q, wp_d;
  logic [LOG2:0]        fill_q, fill_d;
  logic signed [DW-1:0] oldest;

  always_comb begin
    oldest = store[wp_q];
    sum_d  = sum_q;
    wp_d   = wp_q;
    fill_d = fill_q;
    if (push) begin
      sum_d = sum_q + SW'(din) - SW'(oldest);
      wp_d  = wp_q + 1'b1;
      if (!fill_q[LOG2]) fill_d = fill_q + 1'b1;
    end
    shr   = sum_q >>> LOG2;
    avg   = shr[DW-1:0];
    ready = fill_q[LOG2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      wp_q   <= '0;
      fill_q <= '0;
      for (int k = 0; k < DEPTH; k++) store[k] <= '0;
    end else begin
      sum_q  <= sum_d;
      wp_q   <= wp_d;
      fill_q <= fill_d;
      if (push) store[wp_q] <= din;
    end
  end
endmodule

// File: rtl/blc_top.sv
`timescale 1ns/1ps
module blc_top
  import blc_pkg::*;
#(
  parameter int unsigned DW       = BLC_DW,
  parameter int unsigned WIN_W    = BLC_WIN_W,
  parameter int unsigned AVG_LOG2 = BLC_AVG_LOG2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic [WIN_W-1:0]     cfg_win_len,
  input  logic signed [DW-1:0] cfg_threshold,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample,
  output logic                 floor_ready,
  output logic                 base_ready
);
  logic                 floor_push;
  logic signed [DW-1:0] win_min;
  logic signed [DW-1:0] floor_avg;
  logic signed [DW-1:0] restored;
  logic                 accept;
  logic signed [DW-1:0] base_avg;
  logic signed [DW-1:0] corrected;
  logic                 ov_d;
  logic signed [DW-1:0] os_d;

  blc_win_min #(.DW(DW), .LW(WIN_W)) u_min (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .din(in_sample),
    .win_len(cfg_win_len), .push(floor_push), .min_out(win_min)
  );

  blc_avg_ring #(.DW(DW), .LOG2(AVG_LOG2)) u_floor (
    .clk(clk), .rst_n(rst_n), .push(floor_push), .din(win_min),
    .avg(floor_avg), .ready(floor_ready)
  );

  blc_sat_sub #(.DW(DW)) u_sub_floor (
    .a(in_sample), .b(floor_avg), .y(restored)
  );

  assign accept = in_valid && (restored < cfg_threshold);

  blc_avg_ring #(.DW(DW), .LOG2(AVG_LOG2)) u_base (
    .clk(clk), .rst_n(rst_n), .push(accept), .din(restored),
    .avg(base_avg), .ready(base_ready)
  );

  blc_sat_sub #(.DW(DW)) u_sub_base (
    .a(restored), .b(base_avg), .y(corrected)
  );

  always_comb begin
    ov_d = in_valid;
    os_d = in_valid ? corrected : out_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid  <= ov_d;
      out_sample <= os_d;
    end
  end
endmodule

// File: rtl/blc_checker.sv
`timescale 1ns/1ps
module blc_checker #(
  parameter int unsigned DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample,
  input logic                 floor_ready,
  input logic                 base_ready,
  input logic                 floor_push,
  input logic                 accept,
  input logic signed [DW-1:0] floor_avg,
  input logic signed [DW-1:0] base_avg
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));

  p_floor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !floor_push |=> $stable(floor_avg));

  p_base_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(base_avg));

  p_floor_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    floor_ready |=> floor_ready);

  p_base_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    base_ready |=> base_ready);
endmodule

bind blc_top blc_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_sample(out_sample), .floor_ready(floor_ready), .base_ready(base_ready),
  .floor_push(floor_push), .accept(accept), .floor_avg(floor_avg),
  .base_avg(base_avg)
);

// File: tb/blc_top_bench.sv
`timescale 1ns/1ps
module blc_top_bench;
  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_sample;
  logic [7:0]         cfg_win_len;
  logic signed [15:0] cfg_threshold;
  logic               out_valid;
  logic signed [15:0] out_sample;
  logic               floor_ready;
  logic               base_ready;

  int checks;
  int failures;
  bit done;

  blc_top u_blc_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_win_len(cfg_win_len), .cfg_threshold(cfg_threshold),
    .out_valid(out_valid), .out_sample(out_sample),
    .floor_ready(floor_ready), .base_ready(base_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Stage-two table: window 200, threshold 100, floor stays zero.
  localparam int NT = 9;
  localparam int TBL_IN  [NT] = '{50, 300, 2000, -32768, 32767, -32768, 1000, 99, 100};
  localparam int TBL_EXP [NT] = '{50, 300, 2000, -32768, 32767, -32256, 2024, 1123, 1122};

  // Reference model state
  int m_r1 [64];
  int m_r2 [64];
  int m_s1, m_s2, m_p1, m_p2, m_c1, m_c2, m_wcnt, m_min;

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 64; k++) begin m_r1[k] = 0; m_r2[k] = 0; end
    m_s1 = 0; m_s2 = 0; m_p1 = 0; m_p2 = 0; m_c1 = 0; m_c2 = 0;
    m_wcnt = 0; m_min = 0;
  endtask

  task automatic model_step(input int x, output int y, output bit acc);
    int fl, r, b, len, cand;
    fl = m_s1 >>> 6;
    r  = sat16(x - fl);
    b  = m_s2 >>> 6;
    y  = sat16(r - b);
    acc = (r < int'(cfg_threshold));
    len = (cfg_win_len == 0) ? 1 : int'(cfg_win_len);
    cand = (m_wcnt == 0) ? x : ((x < m_min) ? x : m_min);
    m_min = cand;
    if (m_wcnt >= len - 1) begin
      m_s1 = m_s1 + cand - m_r1[m_p1];
      m_r1[m_p1] = cand;
      m_p1 = (m_p1 + 1) % 64;
      m_c1++;
      m_wcnt = 0;
    end else begin
      m_wcnt++;
    end
    if (acc) begin
      m_s2 = m_s2 + r - m_r2[m_p2];
      m_r2[m_p2] = r;
      m_p2 = (m_p2 + 1) % 64;
      m_c2++;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // Drive one sample; check outputs 1 ns after the capturing edge.
  task automatic send(input int x, input bit use_model, input int texp, input string tag);
    int y;
    bit acc;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 16'(x);
    model_step(x, y, acc);
    if (!use_model) y = texp;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R1 out_valid after sample", int'(out_valid), 1);
    chk(int'(out_sample) == y, acc ? {tag, " R5 accepted"} : {tag, " R6 rejected"},
        int'(out_sample), y);
    if (use_model) begin
      chk(floor_ready == (m_c1 >= 64), "R9 floor_ready", int'(floor_ready), int'(m_c1 >= 64));
      chk(base_ready == (m_c2 >= 64), "R9 base_ready", int'(base_ready), int'(m_c2 >= 64));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic signed [15:0] held;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    cfg_win_len = 8'd200; cfg_threshold = 16'sd100;
    model_reset();
    #12;
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid reset", int'(out_valid), 0);
    chk(out_sample == 16'sd0, "R10 out_sample reset", int'(out_sample), 0);
    chk(floor_ready == 1'b0, "R10 floor_ready reset", int'(floor_ready), 0);
    chk(base_ready == 1'b0, "R10 base_ready reset", int'(base_ready), 0);
    do_reset();

    // Table walk: R4 R5 R7 R8 (32767 case saturates)
    for (int i = 0; i < NT; i++) begin
      send(TBL_IN[i], 1'b0, TBL_EXP[i], "R7 R8 table");
    end

    // R1: idle cycle keeps output
    held = out_sample;
    @(negedge clk);
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 idle out_valid", int'(out_valid), 0);
    chk(out_sample == held, "R1 idle hold", int'(out_sample), int'(held));

    // Ramp with peaks, window 4: R2 R3 R9 against model
    cfg_win_len = 8'd4; cfg_threshold = 16'sd200;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      int x;
      x = 400 - i + (i % 5) * 7 + (((i % 13) == 3) ? 5000 : 0);
      send(x, 1'b1, 0, "R2 R3 R7 ramp");
      if (i == 254) chk(floor_ready == 1'b0, "R9 floor not ready at 63 pushes", int'(floor_ready), 0);
      if (i == 255) chk(floor_ready == 1'b1, "R9 floor ready at 64 pushes", int'(floor_ready), 1);
    end

    // Window length zero acts as one; negative saturation via floor: R2 R8
    cfg_win_len = 8'd0; cfg_threshold = 16'sd32767;
    do_reset();
    for (int i = 0; i < 70; i++) begin
      send(30000, 1'b1, 0, "R2 len0");
      if (i == 62) chk(floor_ready == 1'b0, "R2 len0 not ready", int'(floor_ready), 0);
      if (i == 63) chk(floor_ready == 1'b1, "R2 len0 ready after 64 samples", int'(floor_ready), 1);
    end
    for (int i = 0; i < 3; i++) begin
      send(-32768, 1'b1, 0, "R8 negative saturation");
    end
    chk(out_sample == -16'sd32768, "R8 clamp at minimum", int'(out_sample), -32768);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule